// File: doc/BRIEF.md
# Zero-Cross Synchronized Power-Line Transmitter

This block sends a stream of single bits over a power-line carrier link. An isolated mains zero-cross signal comes in as a square wave whose level flips at every polarity reversal. The block brings that signal into the clock domain, and every rising or falling edge opens one bit slot. In each slot the next bit is taken from a circular bit queue. For a one, the transmit-enable output goes high for a fixed 1 ms pulse. An external carrier generator keys its carrier from this output. For a zero, the output stays low.

A host pushes bits through a one-bit write strobe and watches the queue's fill count and its full and empty flags. The length of the pulse comes from a counter that is loaded in the same cycle the pulse starts. Its terminal count is worked out from a system-clock frequency parameter, so the release never drifts against a free-running tick.

Two sticky flags record the cases where work was lost. One flag sets when a write arrives while the queue is full. The other sets when a zero-cross edge arrives while a pulse is still running. Both flags clear only on reset.

Top module: `zc_line_tx`

## Requirements
- R1: A change of level on `zc_in` in either direction opens a bit slot. When the bit taken is a one, `tx_en` goes high on the third rising clock edge after the input changes: two synchronizer stages and one output register.
- R2: A one keeps `tx_en` high for exactly CLK_HZ/1000 clock cycles, which is 1 ms. It then returns low.
- R3: A zero keeps `tx_en` low for the whole slot. The zero is still consumed, so `q_count` drops by one.
- R4: Bits go out in the order they were written.
- R5: When a slot opens with the queue empty, nothing is sent and the queue is untouched. A bit written afterwards goes out at the next edge.
- R6: An edge that arrives while `tx_en` is high is ignored. No bit is consumed, the running pulse keeps its full length, and `overrun` sets and stays set until reset.
- R7: The queue holds DEPTH bits (64 by default), and `q_full` is high exactly when it holds DEPTH bits. A write while the queue is full is dropped and sets the sticky `wr_dropped` flag. The bits already held are kept.
- R8: After reset, `tx_en` is low, `q_empty` is high, `q_full` is low, `q_count` is 0, and both sticky flags are low.
- R9: `q_count` always equals accepted writes minus consumed bits, and `q_empty` is high exactly when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zc_in | input | 1 | Isolated mains zero-cross square wave, asynchronous |
| wr_en | input | 1 | Write strobe: push `wr_bit` into the queue |
| wr_bit | input | 1 | Bit value to queue |
| q_full | output | 1 | Queue holds DEPTH bits |
| q_empty | output | 1 | Queue holds no bits |
| q_count | output | $clog2(DEPTH+1) | Number of bits waiting |
| wr_dropped | output | 1 | Sticky: a write to a full queue was lost |
| overrun | output | 1 | Sticky: an edge arrived during an active pulse |
| tx_en | output | 1 | Transmit enable to the carrier generator |

## Verification
The assertions check these rules on every cycle:
- a pulse never exceeds, and always ends at, the 1 ms cycle count;
- every pulse start follows a detected zero-cross edge;
- an edge during a pulse consumes nothing;
- an edge on an empty queue starts nothing;
- the full flag matches the count;
- both sticky flags hold once set.

Only the bench scenarios can show that bits leave in write order, that a zero is consumed silently, and that the latency from a level change on the pin to the output is exactly three clocks. The same applies to which bits survive an overfilled queue.

// File: rtl/zc_tx_pkg.sv
package zc_tx_pkg;
  // Clock cycles in one pulse of length 1/rate_hz seconds.
  function automatic int pulse_cycles(input int clk_hz, input int rate_hz);
    return clk_hz / rate_hz;
  endfunction

  // Width needed to hold a value from 0 to n.
  function automatic int count_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/zc_edge_det.sv
module zc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_o
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  // Either polarity of change marks a slot.
  assign edge_o = sync_q ^ last_q;
endmodule

// File: rtl/zc_bit_queue.sv
module zc_bit_queue #(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH),
  localparam int CW = (DEPTH < 1) ? 1 : $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          push_bit,
  input  logic          pop,
  output logic          head_bit,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DEPTH-1:0] store_q;
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    count_q;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      store_q  <= '0;
    end else begin
      if (push) begin
        store_q[wr_ptr_q] <= push_bit;
        wr_ptr_q          <= ptr_step(wr_ptr_q);
      end
      if (pop) rd_ptr_q <= ptr_step(rd_ptr_q);
      count_q <= count_q + CW'(push) - CW'(pop);
    end
  end

  assign head_bit = store_q[rd_ptr_q];
  assign count    = count_q;
  assign empty    = (count_q == '0);
  assign full     = (count_q == FULL_CNT);
endmodule

// File: rtl/zc_pulse_timer.sv
module zc_pulse_timer #(
  parameter int PULSE_CYC = 50000,
  localparam int TW = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam logic [TW-1:0] LOAD_VAL = TW'(PULSE_CYC - 1);

  logic [TW-1:0] remain_q;
  logic          active_q;

  // The counter is loaded in the same cycle the pulse starts.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      remain_q <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      remain_q <= LOAD_VAL;
    end else if (active_q) begin
      if (remain_q == '0) active_q <= 1'b0;
      else                remain_q <= remain_q - 1'b1;
    end
  end

  assign active = active_q;
endmodule

// File: rtl/zc_line_tx.sv
module zc_line_tx #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int RATE_HZ = 1000,
  parameter int DEPTH   = 64,
  localparam int PULSE_CYC = zc_tx_pkg::pulse_cycles(CLK_HZ, RATE_HZ),
  localparam int CW = zc_tx_pkg::count_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          zc_in,
  input  logic          wr_en,
  input  logic          wr_bit,
  output logic          q_full,
  output logic          q_empty,
  output logic [CW-1:0] q_count,
  output logic          wr_dropped,
  output logic          overrun,
  output logic          tx_en
);
  // Named internal events, also observed by the checker.
  logic edge_w, pop_w, push_w, start_w, head_bit_w, clash_w, drop_w;
  logic wr_dropped_q, overrun_q;

  zc_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .async_in(zc_in), .edge_o(edge_w)
  );

  assign push_w  = wr_en & ~q_full;
  assign drop_w  = wr_en & q_full;
  assign pop_w   = edge_w & ~tx_en & ~q_empty;
  assign start_w = pop_w & head_bit_w;
  assign clash_w = edge_w & tx_en;

  zc_bit_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push_w), .push_bit(wr_bit),
    .pop(pop_w), .head_bit(head_bit_w), .full(q_full),
    .empty(q_empty), .count(q_count)
  );

  zc_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_w), .active(tx_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_dropped_q <= 1'b0;
      overrun_q    <= 1'b0;
    end else begin
      if (drop_w)  wr_dropped_q <= 1'b1;
      if (clash_w) overrun_q    <= 1'b1;
    end
  end

  assign wr_dropped = wr_dropped_q;
  assign overrun    = overrun_q;
endmodule

// File: rtl/zc_line_tx_chk.sv
module zc_line_tx_chk #(
  parameter int DEPTH = 64,
  parameter int PULSE_CYC = 50000,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          edge_w,
  input logic          pop_w,
  input logic          wr_en,
  input logic          tx_en,
  input logic          q_empty,
  input logic          q_full,
  input logic [CW-1:0] q_count,
  input logic          overrun,
  input logic          wr_dropped
);
  int run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)     run_len <= 0;
    else if (tx_en) run_len <= run_len + 1;
    else            run_len <= 0;
  end

  // R2
  pulse_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> (run_len < PULSE_CYC));
  // R2
  pulse_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> (run_len == PULSE_CYC));
  // R1
  pulse_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(edge_w));
  // R6
  clash_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_w && tx_en && !wr_en) |=> (q_count == $past(q_count)));
  // R6
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R5
  empty_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_w && q_empty && !tx_en) |=> !tx_en);
  // R7
  full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_full == (q_count == CW'(DEPTH)));
  // R7
  dropped_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dropped |=> wr_dropped);
  // R9
  empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty == (q_count == '0));
  // R9
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_w |-> !q_empty);
endmodule

bind zc_line_tx zc_line_tx_chk #(.DEPTH(DEPTH), .PULSE_CYC(PULSE_CYC), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_w(edge_w), .pop_w(pop_w), .wr_en(wr_en),
  .tx_en(tx_en), .q_empty(q_empty), .q_full(q_full), .q_count(q_count),
  .overrun(overrun), .wr_dropped(wr_dropped)
);

// File: tb/zc_line_tx_bench.sv
module zc_line_tx_bench;
  localparam int CLK_HZ = 20_000;
  localparam int DEPTH  = 64;
  localparam int CW     = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0, zc_in = 1'b0, wr_en = 1'b0, wr_bit = 1'b0;
  logic q_full, q_empty, wr_dropped, overrun, tx_en;
  logic [CW-1:0] q_count;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit model_q[$];

  always #5 clk = ~clk;

  zc_line_tx #(.CLK_HZ(CLK_HZ), .RATE_HZ(1000), .DEPTH(DEPTH)) u_zc_line_tx (
    .clk(clk), .rst_n(rst_n), .zc_in(zc_in), .wr_en(wr_en), .wr_bit(wr_bit),
    .q_full(q_full), .q_empty(q_empty), .q_count(q_count),
    .wr_dropped(wr_dropped), .overrun(overrun), .tx_en(tx_en)
  );

  // Expected pulse width in cycles for one bit: 1 ms of the clock.
  function automatic int want_width(input bit b);
    return b ? (CLK_HZ / 1000) : 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input bit b);
    @(negedge clk);
    wr_en = 1'b1; wr_bit = b;
    @(negedge clk);
    wr_en = 1'b0;
    if (model_q.size() < DEPTH) model_q.push_back(b);
  endtask

  // Toggle zc_in, check the latency and width of the slot.
  task automatic slot(input string req);
    bit exp_bit;
    int width;
    bit had = (model_q.size() != 0);
    exp_bit = had ? model_q.pop_front() : 1'b0;
    @(negedge clk); zc_in = ~zc_in;
    @(negedge clk); @(negedge clk);
    check(tx_en == 1'b0, {req, " R1 early"}, int'(tx_en), 0);
    @(negedge clk);
    check(tx_en == exp_bit, {req, " R1 latency"}, int'(tx_en), int'(exp_bit));
    width = tx_en ? 1 : 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tx_en) width++;
    end
    check(width == want_width(exp_bit), {req, " R2 width"}, width, want_width(exp_bit));
    check(int'(q_count) == model_q.size(), {req, " R9 count"}, int'(q_count), model_q.size());
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R8
    check(!tx_en && q_empty && !q_full && q_count == 0 && !overrun && !wr_dropped,
          "R8 reset", int'(tx_en), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5: edge on empty queue
    slot("R5 empty");
    check(q_empty == 1'b1, "R5 still empty", int'(q_empty), 1);
    push(1'b1);
    slot("R5 after load");

    // R3: zero consumed silently
    push(1'b0);
    check(int'(q_count) == 1, "R3 loaded", int'(q_count), 1);
    slot("R3 zero");

    // R4: random order, seeded
    void'($urandom(32'h5eed));
    for (int i = 0; i < 24; i++) push(1'($urandom_range(0, 1)));
    for (int i = 0; i < 24; i++) slot("R4 order");

    // R6: edge during an active pulse
    push(1'b1); push(1'b1);
    begin
      int width = 0;
      @(negedge clk); zc_in = ~zc_in;
      repeat (8) begin @(negedge clk); if (tx_en) width++; end
      zc_in = ~zc_in;
      repeat (30) begin @(negedge clk); if (tx_en) width++; end
      check(width == want_width(1'b1), "R6 pulse kept", width, want_width(1'b1));
      check(overrun == 1'b1, "R6 overrun", int'(overrun), 1);
      check(int'(q_count) == 1, "R6 no pop", int'(q_count), 1);
    end
    void'(model_q.pop_front());
    slot("R6 next slot");
    check(overrun == 1'b1, "R6 sticky", int'(overrun), 1);

    // R7: overfill
    check(wr_dropped == 1'b0, "R7 no drop yet", int'(wr_dropped), 0);
    for (int i = 0; i < DEPTH + 6; i++) push(1'(i % 3 == 0));
    check(q_full == 1'b1, "R7 full", int'(q_full), 1);
    check(int'(q_count) == DEPTH, "R7 count", int'(q_count), DEPTH);
    check(wr_dropped == 1'b1, "R7 dropped", int'(wr_dropped), 1);
    for (int i = 0; i < DEPTH; i++) slot("R7 drain");
    check(q_empty == 1'b1, "R9 empty after drain", int'(q_empty), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule